// File: doc/BRIEF.md
# Automatic Offset DAC Tracker

This block keeps the data average of a capacitance-to-digital converter inside the useful middle of its span. It does this by moving a 6-bit offset DAC code up or down. Each conversion ends with a valid strobe that carries the current average. If the average has climbed past three quarters of full scale, the code goes up. If it has dropped under one quarter of full scale, the code goes down. The size of the step depends on the input-range code that is selected.

Tracking runs only when all three of these hold: the auto bit is set, adaptive threshold mode is selected, and the offset DAC is enabled. A host write of a DAC value always takes priority over tracking. The code saturates at zero and at its maximum; it never wraps.

A small state machine records the action taken at the most recent clock edge:
- `ST_OFF`: tracking is disabled.
- `ST_WAIT`: tracking is armed, but no change was made.
- `ST_UP`: the code was raised.
- `ST_DOWN`: the code was lowered.
- `ST_LOAD`: a host value was loaded.

The transitions, evaluated in priority order every cycle, are:
- `host write` goes to `ST_LOAD`.
- `inactive` goes to `ST_OFF`.
- `strobe above high trip, not at max` goes to `ST_UP`.
- `strobe below low trip, not at zero` goes to `ST_DOWN`.
- anything else goes to `ST_WAIT`.

Top module: `auto_offset_tracker`

## Requirements
- R1: After reset the DAC code is 0x00 and the adjust event output is low.
- R2: When tracking is active and a strobe arrives with the average strictly greater than three quarters of full scale (0xC000 for 16 bits), the code rises by one step at the next clock edge. The adjust event is high for that one cycle.
- R3: When tracking is active and a strobe arrives with the average strictly less than one quarter of full scale (0x4000 for 16 bits), the code falls by one step at the next clock edge. The adjust event is high for that one cycle.
- R4: The step size comes from the range code: 2'b00 gives 4, 2'b01 gives 1, 2'b10 gives 2 and 2'b11 gives 8.
- R5: The code saturates at 0x3F when rising and at 0x00 when falling. A strobe that cannot change the code leaves the adjust event low.
- R6: When fixed threshold mode is selected, or the auto bit is clear, strobes do not change the code.
- R7: When the DAC enable is low, the output code is 0x00 and the tracked code is frozen. Raising the enable again shows the held value.
- R8: A host write loads the host value at the next clock edge. It has priority over any strobe in the same cycle and raises no adjust event.
- R9: A trip causes at most one step per strobe. Cycles without a strobe, and averages equal to or between the trip points, leave the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_in | input | AVG_W | Current converter data average |
| avg_valid | input | 1 | One-cycle strobe per completed conversion |
| range_sel | input | 2 | Input-range code that selects the step size |
| thr_fixed | input | 1 | 1 = fixed threshold mode, 0 = adaptive mode |
| auto_en | input | 1 | Automatic adjustment enable |
| dac_en | input | 1 | Offset DAC enable |
| host_wr | input | 1 | Host write strobe for the DAC value |
| host_val | input | DAC_W | Host-written DAC value |
| dac_code | output | DAC_W | DAC code in use (0 while the DAC is disabled) |
| adj_evt | output | 1 | High for one cycle after a tracking step changes the code |

## Verification
The assertions assume that the inputs are settled before each rising edge, and that `host_val` is valid whenever `host_wr` is high. They also assume that an adjust event can only follow a strobe on the previous cycle. They do not assume strobe spacing, so strobes may arrive on back-to-back cycles.

The stimulus changes every input on the falling edge, one cycle at a time. It sets averages exactly on the trip points and one count on either side of them. It steers the code into both saturation limits, including a host write and a tripping strobe in the same cycle.

// File: rtl/aot_pkg.sv
package aot_pkg;

    localparam int STEP_W = 4;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAIT = 3'd1,
        ST_UP   = 3'd2,
        ST_DOWN = 3'd3,
        ST_LOAD = 3'd4
    } trk_state_e;

    // Step size selected by the input-range code (R4)
    function automatic logic [STEP_W-1:0] step_for_range(input logic [1:0] rng);
        logic [STEP_W-1:0] s;
        unique case (rng)
            2'b00:   s = 4'd4;
            2'b01:   s = 4'd1;
            2'b10:   s = 4'd2;
            default: s = 4'd8;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/aot_trip_detect.sv
module aot_trip_detect #(
    parameter int AVG_W = 16
) (
    input  logic [AVG_W-1:0] avg_in,
    output logic             trip_hi,
    output logic             trip_lo
);

    localparam logic [AVG_W-1:0] LOW_TRIP  = {2'b01, {(AVG_W-2){1'b0}}};
    localparam logic [AVG_W-1:0] HIGH_TRIP = {2'b11, {(AVG_W-2){1'b0}}};

    always_comb begin
        trip_hi = (avg_in > HIGH_TRIP);
        trip_lo = (avg_in < LOW_TRIP);
    end

    always_comb begin
        assert (!(trip_hi && trip_lo))
            else $error("p_trip_exclusive_r9: both trip points seen at once");
    end

endmodule

// File: rtl/aot_ctrl_fsm.sv
module aot_ctrl_fsm
    import aot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       active,
    input  logic       avg_valid,
    input  logic       trip_hi,
    input  logic       trip_lo,
    input  logic       at_max,
    input  logic       at_min,
    output trk_state_e state_next,
    output trk_state_e state_q,
    output logic       adj_evt
);

    // Next-state selection, in priority order
    always_comb begin
        if (host_wr)
            state_next = ST_LOAD;
        else if (!active)
            state_next = ST_OFF;
        else if (avg_valid && trip_hi && !at_max)
            state_next = ST_UP;
        else if (avg_valid && trip_lo && !at_min)
            state_next = ST_DOWN;
        else
            state_next = ST_WAIT;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_next;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_UP, ST_DOWN:           adj_evt = 1'b1;
            ST_OFF, ST_WAIT, ST_LOAD: adj_evt = 1'b0;
            default:                  adj_evt = 1'b0;
        endcase
    end

    p_evt_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adj_evt |-> $past(avg_valid));

    p_load_no_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> !adj_evt);

endmodule

// File: rtl/aot_code_reg.sv
module aot_code_reg
    import aot_pkg::*;
#(
    parameter int DAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trk_state_e        state_next,
    input  logic [DAC_W-1:0]  host_val,
    input  logic [STEP_W-1:0] step,
    output logic [DAC_W-1:0]  code_q,
    output logic              at_max,
    output logic              at_min
);

    localparam logic [DAC_W-1:0] CODE_MAX = {DAC_W{1'b1}};
    localparam int SUM_W = DAC_W + 1;

    logic [SUM_W-1:0] step_ext;
    logic [SUM_W-1:0] sum_up;
    logic [DAC_W-1:0] code_up;
    logic [DAC_W-1:0] code_dn;

    always_comb begin
        step_ext = {{(SUM_W-STEP_W){1'b0}}, step};
        sum_up   = {1'b0, code_q} + step_ext;
        code_up  = (sum_up > {1'b0, CODE_MAX}) ? CODE_MAX : sum_up[DAC_W-1:0];
        code_dn  = ({1'b0, code_q} < step_ext) ? '0 : (code_q - step_ext[DAC_W-1:0]);
        at_max   = (code_q == CODE_MAX);
        at_min   = (code_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            unique case (state_next)
                ST_UP:   code_q <= code_up;
                ST_DOWN: code_q <= code_dn;
                ST_LOAD: code_q <= host_val;
                default: code_q <= code_q;
            endcase
        end
    end

    p_host_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_next == ST_LOAD) |=> (code_q == $past(host_val)));

endmodule

// File: rtl/auto_offset_tracker.sv
module auto_offset_tracker
    import aot_pkg::*;
#(
    parameter int AVG_W = 16,
    parameter int DAC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AVG_W-1:0] avg_in,
    input  logic             avg_valid,
    input  logic [1:0]       range_sel,
    input  logic             thr_fixed,
    input  logic             auto_en,
    input  logic             dac_en,
    input  logic             host_wr,
    input  logic [DAC_W-1:0] host_val,
    output logic [DAC_W-1:0] dac_code,
    output logic             adj_evt
);

    localparam int MAX_STEP = 8;

    logic              trip_hi;
    logic              trip_lo;
    logic              at_max;
    logic              at_min;
    logic              active;
    logic [STEP_W-1:0] step;
    logic [DAC_W-1:0]  code_q;
    trk_state_e        state_next;
    trk_state_e        state_q;

    always_comb begin
        active = auto_en && !thr_fixed && dac_en;
        step   = step_for_range(range_sel);
    end

    aot_trip_detect #(.AVG_W(AVG_W)) u_trip (
        .avg_in (avg_in),
        .trip_hi(trip_hi),
        .trip_lo(trip_lo)
    );

    aot_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .active    (active),
        .avg_valid (avg_valid),
        .trip_hi   (trip_hi),
        .trip_lo   (trip_lo),
        .at_max    (at_max),
        .at_min    (at_min),
        .state_next(state_next),
        .state_q   (state_q),
        .adj_evt   (adj_evt)
    );

    aot_code_reg #(.DAC_W(DAC_W)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_next(state_next),
        .host_val  (host_val),
        .step      (step),
        .code_q    (code_q),
        .at_max    (at_max),
        .at_min    (at_min)
    );

    assign dac_code = dac_en ? code_q : '0;

    p_quiet_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!avg_valid && !host_wr) |=> $stable(code_q));

    p_fixed_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_fixed || !auto_en) && !host_wr) |=> $stable(code_q));

    p_disabled_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_en && !host_wr) |=> $stable(code_q));

    p_evt_real_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adj_evt |-> (code_q != $past(code_q)));

    p_up_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP) |-> (code_q > $past(code_q)));

    p_down_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |-> (code_q < $past(code_q)));

    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP) |-> ((code_q - $past(code_q)) <= DAC_W'(MAX_STEP)));

endmodule

// File: tb/test_auto_offset_tracker.sv
module test_auto_offset_tracker;

    localparam int AVG_W = 16;
    localparam int DAC_W = 6;

    typedef struct {
        logic [DAC_W-1:0] code;
        logic             evt;
        int               req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AVG_W-1:0] avg_in = 16'h8000;
    logic             avg_valid = 1'b0;
    logic [1:0]       range_sel = 2'b00;
    logic             thr_fixed = 1'b0;
    logic             auto_en = 1'b1;
    logic             dac_en = 1'b1;
    logic             host_wr = 1'b0;
    logic [DAC_W-1:0] host_val = '0;
    logic [DAC_W-1:0] dac_code;
    logic             adj_evt;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    int   m_code = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    auto_offset_tracker #(.AVG_W(AVG_W), .DAC_W(DAC_W)) i_auto_offset_tracker (
        .clk(clk), .rst_n(rst_n), .avg_in(avg_in), .avg_valid(avg_valid),
        .range_sel(range_sel), .thr_fixed(thr_fixed), .auto_en(auto_en),
        .dac_en(dac_en), .host_wr(host_wr), .host_val(host_val),
        .dac_code(dac_code), .adj_evt(adj_evt)
    );

    function automatic int step_of(input logic [1:0] r);
        case (r)
            2'b00:   return 4;
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 8;
        endcase
    endfunction

    // Driver: apply one cycle of stimulus, predict the result, push it
    task automatic drive(input logic v, input logic [AVG_W-1:0] a, input logic [1:0] r,
                         input logic fx, input logic au, input logic en,
                         input logic wr, input logic [DAC_W-1:0] hv, input int req);
        exp_t e;
        int   prev;
        @(negedge clk);
        avg_valid = v; avg_in = a; range_sel = r; thr_fixed = fx;
        auto_en = au; dac_en = en; host_wr = wr; host_val = hv;
        prev = m_code;
        if (wr) begin
            m_code = int'(hv);
        end else if (au && !fx && en && v) begin
            if (a > 16'hC000) m_code = (m_code + step_of(r) > 63) ? 63 : m_code + step_of(r);
            else if (a < 16'h4000) m_code = (m_code < step_of(r)) ? 0 : m_code - step_of(r);
        end
        e.code = en ? DAC_W'(m_code) : '0;
        e.evt  = !wr && (m_code != prev);
        e.req  = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare each predicted item after its clock edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (dac_code !== e.code || adj_evt !== e.evt) begin
                n_fail++;
                $display("FAIL R%0d: code=%0d evt=%0b expected code=%0d evt=%0b",
                         e.req, dac_code, adj_evt, e.code, e.evt);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        n_checks++;
        if (dac_code !== '0 || adj_evt !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: code=%0d evt=%0b expected code=0 evt=0", dac_code, adj_evt);
        end
        // R2: high trips step up by 4
        drive(1, 16'hF000, 2'b00, 0, 1, 1, 0, 0, 2);
        drive(1, 16'hF000, 2'b00, 0, 1, 1, 0, 0, 2);
        drive(1, 16'hC001, 2'b00, 0, 1, 1, 0, 0, 2);
        // R9: no strobe, no change; boundaries hold
        drive(0, 16'hF000, 2'b00, 0, 1, 1, 0, 0, 9);
        drive(1, 16'hC000, 2'b00, 0, 1, 1, 0, 0, 9);
        drive(1, 16'h4000, 2'b00, 0, 1, 1, 0, 0, 9);
        drive(1, 16'h8000, 2'b00, 0, 1, 1, 0, 0, 9);
        // R3: low trips step down
        drive(1, 16'h3FFF, 2'b00, 0, 1, 1, 0, 0, 3);
        drive(1, 16'h0000, 2'b00, 0, 1, 1, 0, 0, 3);
        // R4: each range step
        drive(1, 16'hFFFF, 2'b01, 0, 1, 1, 0, 0, 4);
        drive(1, 16'hFFFF, 2'b10, 0, 1, 1, 0, 0, 4);
        drive(1, 16'hFFFF, 2'b11, 0, 1, 1, 0, 0, 4);
        drive(1, 16'h0100, 2'b10, 0, 1, 1, 0, 0, 4);
        // R6: fixed mode and auto off ignore strobes
        drive(1, 16'hFFFF, 2'b11, 1, 1, 1, 0, 0, 6);
        drive(1, 16'h0000, 2'b11, 0, 0, 1, 0, 0, 6);
        drive(0, 16'h8000, 2'b11, 0, 1, 1, 0, 0, 6);
        // R7: disabled DAC shows zero and freezes
        drive(1, 16'hFFFF, 2'b11, 0, 1, 0, 0, 0, 7);
        drive(1, 16'h0000, 2'b11, 0, 1, 0, 0, 0, 7);
        drive(0, 16'h8000, 2'b11, 0, 1, 1, 0, 0, 7);
        // R8: host write wins over a tripping strobe
        drive(1, 16'hFFFF, 2'b11, 0, 1, 1, 1, 6'd60, 8);
        // R5: saturation at top
        drive(1, 16'hFFFF, 2'b11, 0, 1, 1, 0, 0, 5);
        drive(1, 16'hFFFF, 2'b11, 0, 1, 1, 0, 0, 5);
        // R8 then R5: saturation at bottom
        drive(0, 16'h8000, 2'b11, 0, 1, 1, 1, 6'd3, 8);
        drive(1, 16'h0000, 2'b11, 0, 1, 1, 0, 0, 5);
        drive(1, 16'h0000, 2'b11, 0, 1, 1, 0, 0, 5);
        // R2: single-LSB climb from zero on back-to-back strobes
        drive(1, 16'hD000, 2'b01, 0, 1, 1, 0, 0, 2);
        drive(1, 16'hD000, 2'b01, 0, 1, 1, 0, 0, 2);
        drive(0, 16'h8000, 2'b01, 0, 1, 1, 0, 0, 9);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule